// File: doc/BRIEF.md
# Ratio-clock crossing FIFO

This block moves flits from one clock domain to another when both clocks are derived from one common reference and one runs at an integer multiple of the other. It sits between a compute tile and its mesh router. Each flit carries a 16-byte payload and a 2-byte sideband. The writer offers a flit with a valid strobe and is held off by a ready signal. The reader sees a registered flit with a valid flag and takes it with a pop strobe.

No Gray-code synchronizers are used. Because the clock ratio is known and edges line up, each side hands its pointer to the other side in a plain register. The faster side updates that register only on edges that coincide with an edge of the slower clock. A phase strobe in the faster domain marks those edges. As a result, every pointer seen in the slower domain is constant for a whole slow period. The full and empty tests are built on these conservative views, so the slot being written and the slot being read are always different within one period of the slower clock.

Top module: `ratio_xing_fifo`

## Requirements
- R1: A flit is the concatenation of a PAYLOAD_W-bit payload (128 by default) and a SIDE_W-bit sideband (16 by default). Both fields reach the read side bit for bit as written.
- R2: Flits leave in the order they were accepted. None is lost and none is delivered twice.
- R3: With no pops, exactly DEPTH+1 flits are accepted: DEPTH in storage and one in the registered read stage. wr_ready is low while that many are held.
- R4: A write offered while wr_ready is low is dropped without changing the FIFO contents. wr_drop is high for the one write-clock cycle after that edge.
- R5: rd_pop while rd_valid is low has no effect. While rd_valid is high and rd_pop is low, rd_valid and the read flit hold.
- R6: A storage slot is never written and read in the same period of the slower clock. The faster side passes its pointer across only on edges that follow a cycle with fast_phase high. fast_phase is high in the fast cycle whose closing edge is also a slower-clock edge, and it is ignored when RATIO is 1.
- R7: When a flit is written into an empty FIFO whose read stage is empty, rd_valid rises at the first read-clock edge after the write-clock edge that accepts the flit.
- R8: After reset, rd_valid is 0, wr_drop is 0, and wr_ready is 1. Both pointers start at slot zero.
- R9: After one pop from a full FIFO, wr_ready returns within one period of the slower clock after the pop edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_valid | input | 1 | Writer offers a flit |
| wr_payload | input | PAYLOAD_W | Flit payload |
| wr_side | input | SIDE_W | Flit sideband |
| wr_ready | output | 1 | Space available; a flit offered now is taken at the next edge |
| wr_drop | output | 1 | Pulse: the previous write was refused |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_pop | input | 1 | Reader takes the presented flit |
| rd_valid | output | 1 | A flit is presented |
| rd_payload | output | PAYLOAD_W | Presented payload |
| rd_side | output | SIDE_W | Presented sideband |
| fast_phase | input | 1 | Faster-domain strobe: the next fast edge is aligned with a slower edge |

## Verification
The bench builds the block with DEPTH 4 and RATIO 2, with the read side fast. This is the tile-to-router case. The small depth makes full reachable within a few writes, which exercises refusal, the drop pulse and the return of space after a single pop. At ratio 2, the pointer hand-off is skipped on every other fast edge, so both the exact first-flit latency and the delayed credit return are observable at the ports.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // Which side of the crossing runs on the faster clock.
  typedef enum logic {
    FAST_RD = 1'b0,
    FAST_WR = 1'b1
  } fast_side_e;

endpackage

// File: rtl/rxf_ptr_pub.sv
// Pointer hand-off register: updated only on edges allowed by en.
module rxf_ptr_pub #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [PW-1:0] ptr_nx,
  output logic [PW-1:0] pub
);

  always_ff @(posedge clk) begin
    if (rst)     pub <= '0;
    else if (en) pub <= ptr_nx;
  end

endmodule

// File: rtl/rxf_store.sv
// Dual-clock storage, one write port and one registered read port.
module rxf_store #(
  parameter int DW = 144,
  parameter int AW = 3
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int N = 1 << AW;

  logic [DW-1:0] mem [N];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/rxf_wr_ctrl.sv
// Write pointer, full test against the read pointer as handed over, refusal flag.
module rxf_wr_ctrl #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [AW:0]   rd_seen,
  output logic          wr_ready,
  output logic          wr_drop,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   ptr_nx
);

  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wp;
  logic          full;
  logic          accept;

  assign full   = (wp[AW] != rd_seen[AW]) && (wp[AW-1:0] == rd_seen[AW-1:0]);
  assign accept = wr_valid && !full;
  assign ptr_nx = wp + PW'(accept);

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      wr_drop <= 1'b0;
    end else begin
      wp      <= ptr_nx;
      wr_drop <= wr_valid && full;
    end
  end

  assign wr_ready = !full;
  assign we       = accept;
  assign waddr    = wp[AW-1:0];

  // R3: occupancy seen by the writer never exceeds the storage depth
  a_r3_no_overrun: assert property (@(posedge clk) disable iff (rst)
    (PW'(wp - rd_seen) <= PW'(DEPTH)))
    else $error("a_r3_no_overrun");

  // R4: a refused write leaves the write pointer where it was
  a_r4_refused_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> $stable(wp))
    else $error("a_r4_refused_ignored");

endmodule

// File: rtl/rxf_rd_ctrl.sv
// Read pointer, empty test against the write pointer as handed over, output stage control.
module rxf_rd_ctrl #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_pop,
  input  logic [AW:0]   wr_seen,
  output logic          rd_valid,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   ptr_nx
);

  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] rp;
  logic          vq;
  logic          empty;
  logic          load;

  assign empty  = (rp == wr_seen);
  assign load   = !empty && (!vq || rd_pop);
  assign ptr_nx = rp + PW'(load);

  always_ff @(posedge clk) begin
    if (rst) begin
      rp <= '0;
      vq <= 1'b0;
    end else begin
      rp <= ptr_nx;
      if (load)        vq <= 1'b1;
      else if (rd_pop) vq <= 1'b0;
    end
  end

  assign rd_valid = vq;
  assign re       = load;
  assign raddr    = rp[AW-1:0];

  // R2: the reader never runs past the writer, nor falls more than a full buffer behind
  a_r2_no_underrun: assert property (@(posedge clk) disable iff (rst)
    (PW'(wr_seen - rp) <= PW'(DEPTH)))
    else $error("a_r2_no_underrun");

endmodule

// File: rtl/ratio_xing_fifo.sv
module ratio_xing_fifo
  import rxf_pkg::*;
#(
  parameter int         PAYLOAD_W = 128,
  parameter int         SIDE_W    = 16,
  parameter int         DEPTH     = 8,
  parameter int         RATIO     = 2,
  parameter fast_side_e FAST_SIDE = FAST_RD
) (
  input  logic                 wr_clk,
  input  logic                 wr_rst,
  input  logic                 wr_valid,
  input  logic [PAYLOAD_W-1:0] wr_payload,
  input  logic [SIDE_W-1:0]    wr_side,
  output logic                 wr_ready,
  output logic                 wr_drop,
  input  logic                 rd_clk,
  input  logic                 rd_rst,
  input  logic                 rd_pop,
  output logic                 rd_valid,
  output logic [PAYLOAD_W-1:0] rd_payload,
  output logic [SIDE_W-1:0]    rd_side,
  input  logic                 fast_phase
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int FW = PAYLOAD_W + SIDE_W;

  logic          we, re;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wr_ptr_nx, rd_ptr_nx;
  logic [PW-1:0] wr_pub, rd_pub;
  logic          wr_pub_en, rd_pub_en;
  logic [FW-1:0] rd_flit;

  // The faster side publishes only on aligned edges; the slower side on all of its edges.
  generate
    if (FAST_SIDE == FAST_RD) begin : g_rd_fast
      assign rd_pub_en = (RATIO == 1) ? 1'b1 : fast_phase;
      assign wr_pub_en = 1'b1;

      // R6: write slot and read slot differ whenever both are active
      a_r6_slot_apart: assert property (@(posedge rd_clk) disable iff (rd_rst || wr_rst)
        (we && re) |-> (waddr != raddr))
        else $error("a_r6_slot_apart");
    end else begin : g_wr_fast
      assign wr_pub_en = (RATIO == 1) ? 1'b1 : fast_phase;
      assign rd_pub_en = 1'b1;

      // R6: write slot and read slot differ whenever both are active
      a_r6_slot_apart: assert property (@(posedge wr_clk) disable iff (rd_rst || wr_rst)
        (we && re) |-> (waddr != raddr))
        else $error("a_r6_slot_apart");
    end
  endgenerate

  rxf_wr_ctrl #(.AW(AW)) u_wr (
    .clk      (wr_clk),
    .rst      (wr_rst),
    .wr_valid (wr_valid),
    .rd_seen  (rd_pub),
    .wr_ready (wr_ready),
    .wr_drop  (wr_drop),
    .we       (we),
    .waddr    (waddr),
    .ptr_nx   (wr_ptr_nx)
  );

  rxf_ptr_pub #(.PW(PW)) u_wr_pub (
    .clk    (wr_clk),
    .rst    (wr_rst),
    .en     (wr_pub_en),
    .ptr_nx (wr_ptr_nx),
    .pub    (wr_pub)
  );

  rxf_rd_ctrl #(.AW(AW)) u_rd (
    .clk      (rd_clk),
    .rst      (rd_rst),
    .rd_pop   (rd_pop),
    .wr_seen  (wr_pub),
    .rd_valid (rd_valid),
    .re       (re),
    .raddr    (raddr),
    .ptr_nx   (rd_ptr_nx)
  );

  rxf_ptr_pub #(.PW(PW)) u_rd_pub (
    .clk    (rd_clk),
    .rst    (rd_rst),
    .en     (rd_pub_en),
    .ptr_nx (rd_ptr_nx),
    .pub    (rd_pub)
  );

  rxf_store #(.DW(FW), .AW(AW)) u_mem (
    .wclk  (wr_clk),
    .we    (we),
    .waddr (waddr),
    .wdata ({wr_side, wr_payload}),
    .rclk  (rd_clk),
    .re    (re),
    .raddr (raddr),
    .rdata (rd_flit)
  );

  assign {rd_side, rd_payload} = rd_flit;

  // R5: an unpopped flit stays presented and unchanged
  a_r5_hold: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_valid && !rd_pop) |=> (rd_valid && $stable(rd_flit)))
    else $error("a_r5_hold");

endmodule

// File: tb/ratio_xing_fifo_bench.sv
module ratio_xing_fifo_bench;

  localparam int CLK_PERIOD = 10;   // fast (read) clock period
  localparam int RATIO      = 2;
  localparam int DEPTH      = 4;
  localparam int PAYLOAD_W  = 128;
  localparam int SIDE_W     = 16;
  localparam int FW         = PAYLOAD_W + SIDE_W;
  localparam int WD_CYCLES  = 60000;

  localparam int M_OFF = 0, M_ALL = 1, M_THIRD = 2, M_CREDIT = 3;

  logic fclk, sclk, rst, fast_phase;
  logic wr_valid, wr_ready, wr_drop;
  logic [PAYLOAD_W-1:0] wr_payload, rd_payload;
  logic [SIDE_W-1:0]    wr_side, rd_side;
  logic rd_pop, rd_valid;

  int ph;
  int n_cmp = 0;
  int n_bad = 0;
  int mode = M_OFF;
  int credits = 0;
  int cyc = 0;
  logic [FW-1:0] exp_q [$];

  ratio_xing_fifo #(
    .PAYLOAD_W (PAYLOAD_W),
    .SIDE_W    (SIDE_W),
    .DEPTH     (DEPTH),
    .RATIO     (RATIO)
  ) u_ratio_xing_fifo (
    .wr_clk     (sclk),
    .wr_rst     (rst),
    .wr_valid   (wr_valid),
    .wr_payload (wr_payload),
    .wr_side    (wr_side),
    .wr_ready   (wr_ready),
    .wr_drop    (wr_drop),
    .rd_clk     (fclk),
    .rd_rst     (rst),
    .rd_pop     (rd_pop),
    .rd_valid   (rd_valid),
    .rd_payload (rd_payload),
    .rd_side    (rd_side),
    .fast_phase (fast_phase)
  );

  // Both clocks from one process so aligned edges share a time step.
  initial begin
    fclk = 1'b0; sclk = 1'b0; ph = 0; fast_phase = 1'b0;
    forever begin
      #(CLK_PERIOD/2);
      fclk = 1'b1;
      ph = (ph + 1) % RATIO;
      if (ph == 0) sclk = 1'b1;
      else if (ph >= (RATIO + 1) / 2) sclk = 1'b0;
      #(CLK_PERIOD/2);
      fclk = 1'b0;
      fast_phase = (ph == RATIO - 1);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] mk(input int i);
    logic [SIDE_W-1:0]    sb;
    logic [PAYLOAD_W-1:0] pl;
    sb = SIDE_W'(i * 37 + 5);
    pl = {32'(i), ~32'(i), 32'(i * 3), 32'h5A5A_0000 | 32'(i)};
    return {sb, pl};
  endfunction

  // Scoreboard monitor and pop driver, all at the fast falling edge.
  always @(negedge fclk) begin
    logic do_pop;
    logic [FW-1:0] e;
    cyc++;
    case (mode)
      M_ALL:    do_pop = 1'b1;
      M_THIRD:  do_pop = (cyc % 3 == 0);
      M_CREDIT: do_pop = (credits > 0);
      default:  do_pop = 1'b0;
    endcase
    if (rst) do_pop = 1'b0;
    if (rd_valid && do_pop) begin
      if (mode == M_CREDIT) credits--;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "flit with nothing outstanding", {rd_side, rd_payload}, '0);
      end else begin
        e = exp_q.pop_front();
        check({rd_side, rd_payload} == e, "R1/R2", "delivered flit",
              {rd_side, rd_payload}, e);
      end
    end
    rd_pop = do_pop;
  end

  // Move to the falling fast edge just before the next write-clock edge.
  task automatic wait_slot();
    do @(negedge fclk); while (ph != RATIO - 1);
  endtask

  task automatic put(input logic [FW-1:0] f);
    wait_slot();
    wr_valid = 1'b1;
    {wr_side, wr_payload} = f;
    while (!wr_ready) wait_slot();
    exp_q.push_back(f);
    @(negedge fclk);
    wr_valid = 1'b0;
  endtask

  task automatic drain(input string req);
    mode = M_ALL;
    for (int k = 0; k < 400 && exp_q.size() != 0; k++) @(negedge fclk);
    repeat (6) @(negedge fclk);
    check(exp_q.size() == 0, req, "all flits delivered", FW'(exp_q.size()), '0);
    check(rd_valid == 1'b0, req, "nothing extra presented", FW'(rd_valid), '0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge fclk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int acc;
    bit got;
    rst = 1'b1; wr_valid = 1'b0; wr_payload = '0; wr_side = '0;
    repeat (8) @(negedge fclk);
    rst = 1'b0;
    @(negedge fclk);

    // R8: reset state
    check(rd_valid == 1'b0, "R8", "rd_valid after reset", FW'(rd_valid), '0);
    check(wr_ready == 1'b1, "R8", "wr_ready after reset", FW'(wr_ready), 1);
    check(wr_drop == 1'b0, "R8", "wr_drop after reset", FW'(wr_drop), '0);

    // R7: first-flit latency into an empty FIFO
    put(mk(0));
    check(rd_valid == 1'b0, "R7", "rd_valid at accepting edge", FW'(rd_valid), '0);
    @(negedge fclk);
    check(rd_valid == 1'b1, "R7", "rd_valid one read edge later", FW'(rd_valid), 1);
    check(rd_payload == mk(0)[PAYLOAD_W-1:0], "R1", "payload field",
          FW'(rd_payload), FW'(mk(0)[PAYLOAD_W-1:0]));
    check(rd_side == mk(0)[FW-1:PAYLOAD_W], "R1", "sideband field",
          FW'(rd_side), FW'(mk(0)[FW-1:PAYLOAD_W]));

    // R3: fill with no pops, one flit already in the read stage
    repeat (4) @(negedge fclk);
    acc = 0;
    for (int i = 1; i <= 10; i++) begin
      wait_slot();
      wr_valid = 1'b1;
      {wr_side, wr_payload} = mk(i);
      if (wr_ready) begin
        exp_q.push_back(mk(i));
        acc++;
      end
    end
    @(negedge fclk);
    wr_valid = 1'b0;
    check(acc == DEPTH, "R3", "extra flits accepted with read stage full", FW'(acc), FW'(DEPTH));
    check(wr_ready == 1'b0, "R3", "wr_ready low when full", FW'(wr_ready), '0);

    // R4: refused write flags a drop for one cycle
    wait_slot();
    wr_valid = 1'b1;
    {wr_side, wr_payload} = mk(99);
    check(wr_ready == 1'b0, "R4", "still full before refused write", FW'(wr_ready), '0);
    @(negedge fclk);
    wr_valid = 1'b0;
    check(wr_drop == 1'b1, "R4", "drop pulse after refused write", FW'(wr_drop), 1);
    wait_slot();
    @(negedge fclk);
    check(wr_drop == 1'b0, "R4", "drop pulse ends", FW'(wr_drop), '0);

    // R9: one pop returns space quickly
    credits = 1;
    mode = M_CREDIT;
    got = 1'b0;
    for (int k = 0; k < 2 * RATIO + 2 && !got; k++) begin
      @(negedge fclk);
      if (wr_ready) got = 1'b1;
    end
    check(got, "R9", "wr_ready back after one pop", FW'(got), 1);
    mode = M_OFF;

    // R2: drain; the refused flit must never appear
    drain("R2");

    // R2: slow irregular reader, gapped writer
    mode = M_THIRD;
    for (int i = 100; i < 130; i++) begin
      put(mk(i));
      if (i % 4 == 0) begin
        wait_slot();
        wait_slot();
      end
    end
    drain("R2");

    // R1: extreme field values; R2: back-to-back with reader always ready
    put({16'hFFFF, {64{2'b10}}});
    put({16'h0000, {64{2'b01}}});
    for (int i = 200; i < 220; i++) put(mk(i));
    drain("R1");

    // R5: pops while empty are ignored
    mode = M_ALL;
    repeat (3) @(negedge fclk);
    check(rd_valid == 1'b0, "R5", "pop on empty leaves rd_valid low", FW'(rd_valid), '0);
    repeat (5) @(negedge fclk);
    check(rd_valid == 1'b0, "R5", "still empty under continuous pop", FW'(rd_valid), '0);
    put(mk(300));
    drain("R5");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule